// File: doc/BRIEF.md
# Multi-Source Interrupt Request Latch

This block sits in front of an eight-input interrupt controller and turns source events into the controller's pending-request vector. More than one source may share a pin, so each pin holds a small count: an assert raises it by one, a deassert lowers it by one, and a pulse does both in that order. A request is latched when a pin's count leaves zero. Each pin is edge or level triggered, as set by a trigger-mode register. In edge mode a request stays latched after the sources drop, and it clears only when the controller acknowledges it. In level mode the request follows the count.

The trigger-mode register is writable and readable. Some positions are fixed to edge, and which ones depends on whether the instance is the primary controller or the cascaded secondary one. Source events are dropped while the controller reports it is not ready. A deassert that would take a count below zero is an error: it is caught, and a sticky flag reports it. Priority resolution and command decoding are outside this block.

Top module: `irq_req_latch`

## Requirements
- R1: After reset the request vector, the trigger-mode register and the error flag are all zero, and every pin count is zero.
- R2: Per pin, assert adds one to the count and deassert subtracts one. A pulse, or an assert and a deassert in the same cycle, is applied as an increment followed by a decrement. The count is 4 bits wide and holds at 15 when incremented there.
- R3: An increment that takes a pin's count from 0 to 1 sets its request bit.
- R4: In level mode (trigger-mode bit 1), any event that leaves the count above zero sets the request bit, and a decrement from 1 to 0 clears it.
- R5: In edge mode (trigger-mode bit 0), a decrement from 1 to 0 leaves the request bit set.
- R6: An acknowledge with pin number p clears request bit p if that pin's count is zero at that point. Otherwise the bit is kept. Acknowledge is honoured whether or not the controller is ready.
- R7: When an event and an acknowledge target the same pin in one cycle, the event is applied first, and the acknowledge then tests the updated count.
- R8: A write stores the data ANDed with a fixed mask, and the register reads back that value. The mask is 0xF8 on the primary instance, keeping pins 0, 1 and 2 edge. It is 0xDE on the secondary instance, keeping pins 0 and 5 edge. The new mode governs events from the next cycle on.
- R9: While ready is low, assert, deassert and pulse strobes change neither the counts nor the request bits.
- R10: A decrement of a zero count leaves the count at zero, leaves the request bit unchanged, and sets an error flag that stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ready | input | 1 | Controller initialised; gates source events |
| ev_assert | input | 8 | Per-pin assert strobe |
| ev_deassert | input | 8 | Per-pin deassert strobe |
| ev_pulse | input | 8 | Per-pin pulse strobe (assert then deassert) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_pin | input | 3 | Pin number being acknowledged |
| tm_wr_en | input | 1 | Trigger-mode register write enable |
| tm_wr_data | input | 8 | Trigger-mode write data (1 = level) |
| tm_mode | output | 8 | Trigger-mode register contents |
| req | output | 8 | Request vector |
| err_underflow | output | 1 | Sticky count-underflow flag |

## Verification
Every result of this block appears one clock after the stimulus that causes it: request bits, the mode register and the error flag are all registered directly from that cycle's strobes. A mode write affects events from the following cycle onward. The bench drives strobes on the falling edge and updates its own arithmetic model of the counts just after the rising edge. It compares the outputs at the next falling edge, so each check falls exactly one register stage after its stimulus. Directed sequences come first, covering saturation, underflow, collision and mask cases. A long pseudo-random sweep follows, and it is compared every cycle.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  // Positions that can never be set to level trigger.
  function automatic logic fixed_edge(input logic is_master, input int pin);
    if (is_master) return (pin <= 2);
    return (pin == 0) || (pin == 5);
  endfunction
endpackage

// File: rtl/irq_trig_mode_reg.sv
module irq_trig_mode_reg #(
  parameter int NUM_PINS  = 8,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [NUM_PINS-1:0] wr_data,
  output logic [NUM_PINS-1:0] mode
);
  import irq_latch_pkg::*;

  logic [NUM_PINS-1:0] keep_mask;
  logic [NUM_PINS-1:0] mode_q;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_mask
    assign keep_mask[g] = !fixed_edge(IS_MASTER, g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= '0;
    else if (wr_en) mode_q <= wr_data & keep_mask;
  end

  assign mode = mode_q;

  // R8: without a write the register holds
  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_q));
endmodule

// File: rtl/irq_pin_slot.sv
module irq_pin_slot #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up,
  input  logic dn,
  input  logic level,
  input  logic ack_hit,
  output logic req,
  output logic underflow
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == CMAX) ? c : c + ONE;
  endfunction

  function automatic logic [CNT_W-1:0] sat_dec(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - ONE;
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_nxt;
  logic             req_q, req_nxt;
  logic             rise_ev, fall_ev, lvl_hold_ev;

  always_comb begin
    cnt_mid = up ? sat_inc(cnt_q) : cnt_q;
    cnt_nxt = dn ? sat_dec(cnt_mid) : cnt_mid;
  end

  assign rise_ev     = up && (cnt_q == '0);
  assign fall_ev     = dn && (cnt_mid == ONE);
  assign underflow   = dn && (cnt_mid == '0);
  assign lvl_hold_ev = level && ((up && cnt_mid != '0) || (dn && cnt_nxt != '0));

  always_comb begin
    req_nxt = req_q;
    if (rise_ev || (level && up && cnt_mid != '0)) req_nxt = 1'b1;
    if (fall_ev && level)                          req_nxt = 1'b0;
    else if (lvl_hold_ev)                          req_nxt = 1'b1;
    if (ack_hit && cnt_nxt == '0)                  req_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      req_q <= req_nxt;
    end
  end

  assign req = req_q;

  assert_rise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !dn && cnt_q == '0) |=> req_q);
  assert_edge_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !level && !ack_hit) |=> req_q);
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !up && !dn && cnt_q == '0) |=> !req_q);
  assert_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !dn && cnt_q == CMAX) |=> (cnt_q == CMAX));
  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (cnt_q == '0));
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int NUM_PINS  = 8,
  parameter int CNT_W     = 4,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ready,
  input  logic [NUM_PINS-1:0]         ev_assert,
  input  logic [NUM_PINS-1:0]         ev_deassert,
  input  logic [NUM_PINS-1:0]         ev_pulse,
  input  logic                        ack_valid,
  input  logic [$clog2(NUM_PINS)-1:0] ack_pin,
  input  logic                        tm_wr_en,
  input  logic [NUM_PINS-1:0]         tm_wr_data,
  output logic [NUM_PINS-1:0]         tm_mode,
  output logic [NUM_PINS-1:0]         req,
  output logic                        err_underflow
);
  localparam int PIN_W = $clog2(NUM_PINS);

  logic [NUM_PINS-1:0] up_v, dn_v, ack_v, uf_v;
  logic                err_q;

  irq_trig_mode_reg #(.NUM_PINS(NUM_PINS), .IS_MASTER(IS_MASTER)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(tm_wr_en), .wr_data(tm_wr_data), .mode(tm_mode)
  );

  assign up_v = {NUM_PINS{ready}} & (ev_assert | ev_pulse);
  assign dn_v = {NUM_PINS{ready}} & (ev_deassert | ev_pulse);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    localparam logic [PIN_W-1:0] PIDX = PIN_W'(g);
    assign ack_v[g] = ack_valid && (ack_pin == PIDX);
    irq_pin_slot #(.CNT_W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .up(up_v[g]), .dn(dn_v[g]),
      .level(tm_mode[g]), .ack_hit(ack_v[g]),
      .req(req[g]), .underflow(uf_v[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (|uf_v)     err_q <= 1'b1;
  end

  assign err_underflow = err_q;

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  assert_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !ack_valid) |=> $stable(req));
  assert_one_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_v));
endmodule

// File: tb/irq_req_latch_test.sv
`timescale 1ns/1ps
module irq_req_latch_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ready = 1'b0;
  logic [7:0] ev_a = '0, ev_d = '0, ev_p = '0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_pin = '0;
  logic       tm_wr_en = 1'b0;
  logic [7:0] tm_wr_data = '0;
  logic [7:0] tm_mode, req;
  logic       err_underflow;
  logic       s_wr_en = 1'b0;
  logic [7:0] s_wr_data = '0;
  logic [7:0] s_mode, s_req;
  logic       s_err;

  int compared = 0;
  int mismatched = 0;
  int cnt_m [8];
  logic [7:0] req_m = '0, mode_m = '0;
  logic err_m = 1'b0;
  logic [31:0] lcg = 32'h1234_5678;

  always #2 clk = ~clk;

  irq_req_latch #(.IS_MASTER(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .ready(ready), .ev_assert(ev_a), .ev_deassert(ev_d),
    .ev_pulse(ev_p), .ack_valid(ack_valid), .ack_pin(ack_pin), .tm_wr_en(tm_wr_en),
    .tm_wr_data(tm_wr_data), .tm_mode(tm_mode), .req(req), .err_underflow(err_underflow)
  );

  irq_req_latch #(.IS_MASTER(1'b0)) uut_slave (
    .clk(clk), .rst_n(rst_n), .ready(1'b0), .ev_assert(8'h00), .ev_deassert(8'h00),
    .ev_pulse(8'h00), .ack_valid(1'b0), .ack_pin(3'd0), .tm_wr_en(s_wr_en),
    .tm_wr_data(s_wr_data), .tm_mode(s_mode), .req(s_req), .err_underflow(s_err)
  );

  task automatic chk(input string tag, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // Reference arithmetic, written from the requirements.
  task automatic model_step();
    for (int p = 0; p < 8; p++) begin
      bit up = ready && (ev_a[p] || ev_p[p]);
      bit dn = ready && (ev_d[p] || ev_p[p]);
      bit lvl = mode_m[p];
      int c = cnt_m[p];
      if (up) begin
        if (c == 0) req_m[p] = 1'b1;
        if (c < 15) c = c + 1;
        if (lvl) req_m[p] = 1'b1;
      end
      if (dn) begin
        if (c == 0) err_m = 1'b1;
        else begin
          c = c - 1;
          if (lvl && c == 0) req_m[p] = 1'b0;
          else if (lvl) req_m[p] = 1'b1;
        end
      end
      if (ack_valid && ack_pin == 3'(p) && c == 0) req_m[p] = 1'b0;
      cnt_m[p] = c;
    end
    if (tm_wr_en) mode_m = tm_wr_data & 8'hF8;
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    #0.5;
    model_step();
    @(negedge clk);
    chk(tag, "req", req, req_m);
    chk(tag, "mode", tm_mode, mode_m);
    chk(tag, "err", {7'd0, err_underflow}, {7'd0, err_m});
    ev_a = '0; ev_d = '0; ev_p = '0; ack_valid = 1'b0; tm_wr_en = 1'b0;
  endtask

  initial begin
    #(4.0 * 200000);
    mismatched++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int p = 0; p < 8; p++) cnt_m[p] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "req", req, 8'h00);
    chk("R1", "mode", tm_mode, 8'h00);
    chk("R1", "err", {7'd0, err_underflow}, 8'h00);
    rst_n = 1'b1;
    ready = 1'b1;
    @(negedge clk);

    // R8 mode masks on both instances
    tm_wr_en = 1'b1; tm_wr_data = 8'hFF; s_wr_en = 1'b1; s_wr_data = 8'hFF;
    cyc("R8");
    s_wr_en = 1'b0;
    chk("R8", "master mode", tm_mode, 8'hF8);
    chk("R8", "slave mode", s_mode, 8'hDE);

    // R4 level pin 3
    ev_a[3] = 1'b1; cyc("R4");
    chk("R4", "req3 set", {7'd0, req[3]}, 8'h01);
    ev_a[3] = 1'b1; cyc("R4");
    ev_d[3] = 1'b1; cyc("R4");
    chk("R4", "req3 held", {7'd0, req[3]}, 8'h01);
    ev_d[3] = 1'b1; cyc("R4");
    chk("R4", "req3 cleared", {7'd0, req[3]}, 8'h00);

    // R5 edge latching, R6 acknowledge
    tm_wr_en = 1'b1; tm_wr_data = 8'h00; cyc("R8");
    ev_a[4] = 1'b1; cyc("R3");
    chk("R3", "req4 set", {7'd0, req[4]}, 8'h01);
    ev_d[4] = 1'b1; cyc("R5");
    chk("R5", "req4 latched", {7'd0, req[4]}, 8'h01);
    ack_valid = 1'b1; ack_pin = 3'd4; cyc("R6");
    chk("R6", "req4 acked", {7'd0, req[4]}, 8'h00);
    ev_a[5] = 1'b1; cyc("R6");
    ev_a[5] = 1'b1; cyc("R6");
    ack_valid = 1'b1; ack_pin = 3'd5; cyc("R6");
    chk("R6", "req5 kept", {7'd0, req[5]}, 8'h01);
    ev_d[5] = 1'b1; cyc("R6");
    ev_d[5] = 1'b1; cyc("R6");
    ack_valid = 1'b1; ack_pin = 3'd5; cyc("R6");
    chk("R6", "req5 acked", {7'd0, req[5]}, 8'h00);

    // R2 pulse and saturation
    ev_p[6] = 1'b1; cyc("R2");
    chk("R2", "req6 pulse", {7'd0, req[6]}, 8'h01);
    for (int i = 0; i < 17; i++) begin ev_a[7] = 1'b1; cyc("R2"); end
    for (int i = 0; i < 15; i++) begin ev_d[7] = 1'b1; cyc("R2"); end
    ack_valid = 1'b1; ack_pin = 3'd7; cyc("R2");
    chk("R2", "req7 after saturate", {7'd0, req[7]}, 8'h00);

    // R10 underflow
    ev_d[1] = 1'b1; cyc("R10");
    chk("R10", "err", {7'd0, err_underflow}, 8'h01);
    ev_a[1] = 1'b1; cyc("R10");
    chk("R10", "req1 after underflow", {7'd0, req[1]}, 8'h01);

    // R9 not ready
    ready = 1'b0; ev_a[2] = 1'b1; cyc("R9");
    chk("R9", "req2", {7'd0, req[2]}, 8'h00);
    ready = 1'b1;
    ack_valid = 1'b1; ack_pin = 3'd2; cyc("R9");

    // R7 event and ack in the same cycle
    ev_a[0] = 1'b1; ack_valid = 1'b1; ack_pin = 3'd0; cyc("R7");
    chk("R7", "req0 kept", {7'd0, req[0]}, 8'h01);
    ev_d[0] = 1'b1; cyc("R7");
    ev_p[0] = 1'b1; ack_valid = 1'b1; ack_pin = 3'd0; cyc("R7");
    chk("R7", "req0 pulse+ack", {7'd0, req[0]}, 8'h00);

    // pseudo-random sweep checked every cycle
    for (int n = 0; n < 4000; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      ready = (lcg[31:29] != 3'd0);
      ev_a = lcg[7:0] & lcg[15:8] & lcg[23:16];
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      ev_d = lcg[7:0] & lcg[15:8] & lcg[23:16];
      ev_p = lcg[27:20] & lcg[11:4] & lcg[19:12] & lcg[7:0];
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      ack_valid = lcg[30] | lcg[29];
      ack_pin = lcg[18:16];
      tm_wr_en = (lcg[15:11] == 5'd0);
      tm_wr_data = lcg[7:0];
      cyc("R7");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule